// File: doc/BRIEF.md
# Bit-Clock and Frame-Sync Generator

This block takes a single synchronous reference clock and derives a slower serial bit clock from it through a programmable divider. It counts the generated bit clocks and emits a periodic frame-sync pulse. The frame period and the pulse width are independent counts, and both are measured in bit clocks rather than in reference cycles. A serial audio or telephony port uses it as its timing master. Typical settings are a 32-bit frame with a 16-bit-wide sync, which gives a 50% duty left/right select for stereo, and a 256-bit frame with a one-bit sync for mono.

Every output is registered. `bclk_tick` is a one-reference-cycle strobe that marks the first reference cycle of each generated bit. `bclk_out` is the bit-clock waveform itself, and its polarity is selectable. `fsync_out` changes only together with a strobe, so it stays aligned to bit boundaries. The configuration inputs are plain levels with no handshake, and the generator runs only while `enable` is high. Dropping `enable` clears every counter, so the next enable starts a fresh frame.

Top module: `frame_sync_gen`

## Requirements
- R1: While `rst_n` is low and on the first cycle after it, `bclk_tick`, `fsync_out` and `bclk_out` are all 0.
- R2: While enabled, `bclk_tick` is high exactly once every `div_val`+1 reference cycles. With `div_val`=0 it is high on every cycle. It is never high on the cycle after `enable` was sampled low.
- R3: Inside each bit, take the reference cycle index c (0 at the strobe). `bclk_out` equals (c <= floor(`div_val`/2)) XOR `clk_invert`. With `div_val`=0 it stays at 1 XOR `clk_invert`.
- R4: While enabled, `fsync_out` changes value only in a cycle where `bclk_tick` is high.
- R5: With bit index k counted from 0 at the first strobe after enable, a frame spans `fperiod`+1 bits. Bit k lies at position k mod (`fperiod`+1) in its frame.
- R6: `fsync_out` is 1 during a bit whose frame position is at most `fwidth`, and 0 otherwise. The pulse is therefore `fwidth`+1 bits wide.
- R7: If `fwidth` >= `fperiod`, `fsync_out` stays at 1 continuously while enabled.
- R8: On the first cycle after `enable` rises, `bclk_tick` and `fsync_out` are both 1. This is the first bit of a new frame, whatever state the block was in when it was disabled.
- R9: One cycle after `enable` is sampled low, `bclk_tick` and `fsync_out` are 0 and `bclk_out` equals `clk_invert`. They stay there while `enable` remains low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Active-low synchronous reset |
| enable | input | 1 | Run control; low clears all counters |
| clk_invert | input | 1 | Inverts the generated bit-clock waveform |
| div_val | input | 10 | Bit period minus one, in reference cycles |
| fwidth | input | 6 | Sync active width minus one, in bits |
| fperiod | input | 13 | Frame period minus one, in bits |
| bclk_tick | output | 1 | One-cycle strobe at the start of each bit |
| bclk_out | output | 1 | Generated bit-clock level |
| fsync_out | output | 1 | Frame-sync level, bit aligned |

## Verification
Two events can fall on the same bit. One is the end of the sync pulse and the other is the frame wrap that restarts it. When `fwidth` equals or exceeds `fperiod`, the bit where the pulse would drop is also the bit where the next frame begins. The bench provokes this with vectors where the width equals the period and where it exceeds the period, and it requires `fsync_out` to stay high over several frames. A second collision is a disable arriving in the middle of a frame with a strobe pending. The bench checks that the outputs go idle on the next cycle and that a re-enable starts on frame position zero.

// File: rtl/fsg_pkg.sv
package fsg_pkg;
  localparam int DIV_W = 10;
  localparam int FW_W  = 6;
  localparam int FP_W  = 13;

  typedef struct packed {
    logic [DIV_W-1:0] div;
    logic [FW_W-1:0]  width;
    logic [FP_W-1:0]  period;
    logic             invert;
  } fsg_cfg_t;
endpackage

// File: rtl/fsg_bit_divider.sv
module fsg_bit_divider #(
  parameter int DIV_W = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic [DIV_W-1:0] div,
  output logic             bit_start,
  output logic             first_half
);
  logic [DIV_W-1:0] cyc_q;

  // Cycle index inside the current bit; cleared whenever not running.
  always_ff @(posedge clk) begin
    if (!rst_n || !run) cyc_q <= '0;
    else if (cyc_q >= div) cyc_q <= '0;
    else cyc_q <= cyc_q + 1'b1;
  end

  assign bit_start  = run && (cyc_q == '0);
  assign first_half = (cyc_q <= (div >> 1));
endmodule

// File: rtl/fsg_frame_counter.sv
module fsg_frame_counter #(
  parameter int FW_W = 6,
  parameter int FP_W = 13
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            run,
  input  logic            advance,
  input  logic [FW_W-1:0] width,
  input  logic [FP_W-1:0] period,
  output logic            sync_level
);
  logic [FP_W-1:0] pos_q;

  // Bit position inside the frame; moves on each bit start.
  always_ff @(posedge clk) begin
    if (!rst_n || !run) pos_q <= '0;
    else if (advance) begin
      if (pos_q >= period) pos_q <= '0;
      else pos_q <= pos_q + 1'b1;
    end
  end

  assign sync_level = (pos_q <= FP_W'(width));
endmodule

// File: rtl/frame_sync_gen.sv
module frame_sync_gen
  import fsg_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             enable,
  input  logic             clk_invert,
  input  logic [DIV_W-1:0] div_val,
  input  logic [FW_W-1:0]  fwidth,
  input  logic [FP_W-1:0]  fperiod,
  output logic             bclk_tick,
  output logic             bclk_out,
  output logic             fsync_out
);
  fsg_cfg_t cfg;
  logic bit_start, first_half, sync_level;
  logic tick_q, bclk_q, fsync_q;

  assign cfg = '{div: div_val, width: fwidth, period: fperiod, invert: clk_invert};

  fsg_bit_divider #(.DIV_W(DIV_W)) u_div (
    .clk        (clk),
    .rst_n      (rst_n),
    .run        (enable),
    .div        (cfg.div),
    .bit_start  (bit_start),
    .first_half (first_half)
  );

  fsg_frame_counter #(.FW_W(FW_W), .FP_W(FP_W)) u_frame (
    .clk        (clk),
    .rst_n      (rst_n),
    .run        (enable),
    .advance    (bit_start),
    .width      (cfg.width),
    .period     (cfg.period),
    .sync_level (sync_level)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tick_q  <= 1'b0;
      bclk_q  <= 1'b0;
      fsync_q <= 1'b0;
    end else if (!enable) begin
      tick_q  <= 1'b0;
      bclk_q  <= cfg.invert;
      fsync_q <= 1'b0;
    end else begin
      tick_q <= bit_start;
      bclk_q <= first_half ^ cfg.invert;
      if (bit_start) fsync_q <= sync_level;
    end
  end

  assign bclk_tick = tick_q;
  assign bclk_out  = bclk_q;
  assign fsync_out = fsync_q;
endmodule

// File: rtl/fsg_checker.sv
module fsg_checker
  import fsg_pkg::*;
(
  input logic             clk,
  input logic             rst_n,
  input logic             enable,
  input logic             clk_invert,
  input logic [DIV_W-1:0] div_val,
  input logic [FW_W-1:0]  fwidth,
  input logic [FP_W-1:0]  fperiod,
  input logic             bclk_tick,
  input logic             bclk_out,
  input logic             fsync_out
);
  AST_IDLE_WHEN_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |=> (!bclk_tick && !fsync_out && bclk_out == $past(clk_invert))); // R9

  AST_FRESH_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(enable) |=> (bclk_tick && fsync_out)); // R8

  AST_FULL_RATE: assert property (@(posedge clk) disable iff (!rst_n)
    (enable && div_val == '0 && $past(enable) && $past(div_val) == '0) |=> bclk_tick); // R2

  AST_TICK_NEEDS_RUN: assert property (@(posedge clk) disable iff (!rst_n)
    bclk_tick |-> $past(enable)); // R2

  AST_SYNC_ON_BIT: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(enable) && !bclk_tick) |-> $stable(fsync_out)); // R4
endmodule

bind frame_sync_gen fsg_checker u_chk (.*);

// File: tb/frame_sync_gen_bench.sv
module frame_sync_gen_bench;
  typedef struct packed {
    logic [9:0]  d;
    logic [5:0]  w;
    logic [12:0] p;
    logic        inv;
  } vec_t;

  localparam int NV = 7;
  localparam vec_t VECS [NV] = '{
    '{10'd3,    6'd15, 13'd31,  1'b0},   // stereo, 50% duty
    '{10'd0,    6'd0,  13'd255, 1'b0},   // mono, full reference rate
    '{10'd0,    6'd5,  13'd5,   1'b0},   // width equals period
    '{10'd2,    6'd10, 13'd3,   1'b1},   // width beyond period
    '{10'd1,    6'd2,  13'd6,   1'b1},   // inverted clock
    '{10'd1023, 6'd0,  13'd1,   1'b0},   // widest divider
    '{10'd4,    6'd0,  13'd0,   1'b0}    // one-bit frame
  };

  logic clk = 1'b0;
  logic rst_n, enable, clk_invert;
  logic [9:0] div_val;
  logic [5:0] fwidth;
  logic [12:0] fperiod;
  logic bclk_tick, bclk_out, fsync_out;
  int total = 0, bad = 0;

  always #5 clk = ~clk;

  frame_sync_gen u_frame_sync_gen (.*);

  task automatic check(input string req, input int act, input int exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic run_vec(input vec_t v);
    int dv, pv, fw, n_cyc;
    int e_tick, e_bclk, e_fs, m_tick, m_bclk, m_fs, m_r4, prev_fs;
    dv = int'(v.d); pv = int'(v.p); fw = int'(v.w);
    @(negedge clk);
    enable = 1'b0; div_val = v.d; fwidth = v.w; fperiod = v.p; clk_invert = v.inv;
    @(posedge clk); @(negedge clk);
    enable = 1'b1;
    n_cyc = (dv + 1) * (pv + 1) * 3;
    if (n_cyc < 24) n_cyc = 24;
    m_tick = 0; m_bclk = 0; m_fs = 0; m_r4 = 0; prev_fs = 0;
    for (int n = 0; n < n_cyc; n++) begin
      @(posedge clk); @(negedge clk);
      e_tick = ((n % (dv + 1)) == 0) ? 1 : 0;
      e_bclk = (((n % (dv + 1)) <= dv / 2) ? 1 : 0) ^ int'(v.inv);
      e_fs   = (((n / (dv + 1)) % (pv + 1)) <= fw) ? 1 : 0;
      if (int'(bclk_tick) != e_tick) m_tick++;
      if (int'(bclk_out) != e_bclk) m_bclk++;
      if (int'(fsync_out) != e_fs) m_fs++;
      if (n > 0 && !bclk_tick && int'(fsync_out) != prev_fs) m_r4++;
      prev_fs = int'(fsync_out);
    end
    check("R2 tick mismatches", m_tick, 0);
    check("R3 bclk mismatches", m_bclk, 0);
    check("R5 R6 R7 fsync mismatches", m_fs, 0);
    check("R4 fsync moved off tick", m_r4, 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    bad++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    rst_n = 1'b0; enable = 1'b1; clk_invert = 1'b1;
    div_val = 10'd2; fwidth = 6'd1; fperiod = 13'd4;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R1 tick in reset", int'(bclk_tick), 0);
    check("R1 fsync in reset", int'(fsync_out), 0);
    check("R1 bclk in reset", int'(bclk_out), 0);
    enable = 1'b0;
    rst_n = 1'b1;
    @(posedge clk); @(negedge clk);
    check("R9 idle bclk follows invert", int'(bclk_out), 1);
    check("R9 idle fsync", int'(fsync_out), 0);

    for (int i = 0; i < NV; i++) run_vec(VECS[i]);

    // Disable mid-frame, then re-enable.
    @(negedge clk);
    enable = 1'b0; div_val = 10'd2; fwidth = 6'd2; fperiod = 13'd6; clk_invert = 1'b0;
    @(posedge clk); @(negedge clk);
    enable = 1'b1;
    repeat (14) begin @(posedge clk); @(negedge clk); end
    enable = 1'b0;
    @(posedge clk); @(negedge clk);
    check("R9 tick after disable", int'(bclk_tick), 0);
    check("R9 fsync after disable", int'(fsync_out), 0);
    check("R9 bclk after disable", int'(bclk_out), 0);
    repeat (5) begin @(posedge clk); @(negedge clk); end
    check("R9 still idle", int'(bclk_tick) + int'(fsync_out), 0);
    enable = 1'b1;
    @(posedge clk); @(negedge clk);
    check("R8 tick on re-enable", int'(bclk_tick), 1);
    check("R8 fsync on re-enable", int'(fsync_out), 1);
    @(posedge clk); @(negedge clk);
    check("R2 no tick mid-bit", int'(bclk_tick), 0);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule